// File: doc/BRIEF.md
# Sync Line Interleave Phase Controller

Several switching converters can share one open-drain synchronization wire. This block provides the switching-period timebase for one of them. Its role comes from static strap inputs. A unit whose interleave-select input is low and whose 5-bit interleave code is all zero acts as the master. The master pulls the wire low once per nominal period, and the length of each low pulse carries one data bit. Every other unit is a slave and only listens.

Each unit recovers the period from the falling edges it sees on the wire, and the master does the same with its own edges. From that period the unit places a one-clock cycle-start strobe at a fraction k/32 of the period after each edge, where k is the effective interleave code. This gives phase lags of 0° to 348.75° in 11.25° steps. As an example, four units on one wire can run at codes 0, 16, 24 and 8, which gives 0°, 180°, 270° and 90°.

The block also checks the received pulse widths and the period length, and it reports when edges stop arriving.

Top module: `sync_phase_ctrl`

## Requirements
- R1: `is_master` is 1 exactly when `ilv_sel` is 0 and `ilv_code` is all zero. A unit that is not master never asserts `sync_pull`.
- R2: A master starts a low pulse every NOM_PERIOD clocks (default 250). It samples `tx_bit` at the start of each period and holds the line low for floor(NOM_PERIOD*25/100) clocks when `tx_bit` is 1, or floor(NOM_PERIOD*75/100) clocks when `tx_bit` is 0.
- R3: For each falling edge of `sync_in`, let edge 1 be the first rising clock edge at which the line is low. `cyc_start` is then high for exactly the one clock cycle that follows rising edge number 2 + floor(P*k/32). Here P is the stored period and k is the effective code.
- R4: The effective code k equals `ilv_code` when `ilv_sel` is 1 and equals 0 when `ilv_sel` is 0.
- R5: P is the distance in clocks between the two most recent falling edges. After reset P is NOM_PERIOD.
- R6: `rx_valid` pulses for one cycle at each rising edge of the line that follows a falling edge, except while loss of sync is flagged. In that cycle `rx_bit` is 1 if twice the low time is less than P and 0 otherwise. `rx_bit` then holds that value.
- R7: `sync_err` goes high after a rising edge when the low time L satisfies neither 22*P <= 100*L <= 28*P nor 72*P <= 100*L <= 78*P. It stays high until the next falling edge.
- R8: A falling-edge interval outside the range floor(NOM*500/525) to floor(NOM*500/475) clocks (238 to 263 by default) is not stored into P. It raises `sync_err` until the next falling edge.
- R9: If no falling edge arrives for 2*NOM_PERIOD clocks, `sync_lost` rises and stays high until the next falling edge. That edge does not update P, and its strobe is placed with the held P.
- R10: During and right after reset, with the line idle high, `cyc_start`, `rx_valid`, `sync_err`, `sync_lost` and `sync_pull` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ilv_sel | input | 1 | 1: use interleave code for phase; 0: phase forced to zero |
| ilv_code | input | CODE_W (5) | Interleave code, 11.25° per step |
| tx_bit | input | 1 | Data bit sent by a master, 1 = short pulse |
| sync_in | input | 1 | Resolved level of the shared sync wire |
| sync_pull | output | 1 | 1 = pull the sync wire low |
| is_master | output | 1 | Unit owns the sync wire |
| cyc_start | output | 1 | One-clock phase-shifted cycle-start strobe |
| rx_bit | output | 1 | Data bit decoded from the last pulse |
| rx_valid | output | 1 | One-clock strobe when `rx_bit` is refreshed |
| sync_err | output | 1 | Pulse width or period outside accepted bands |
| sync_lost | output | 1 | No edge for two nominal periods |

## Verification
A corrupted stored period does not stay internal. It shifts the strobe of the very next edge away from 2 + floor(P*k/32), and it shifts the decision threshold for `rx_bit`. Both effects appear within one sync period. A wrong loss-of-sync state is visible in two ways: `sync_lost` itself, and a strobe after resumption that is placed with a period that was never held. An error flag that clears at the wrong point appears as `sync_err` being high at the end of an otherwise clean period.

// File: rtl/sph_pkg.sv
package sph_pkg;

  typedef enum logic {
    ROLE_SLAVE  = 1'b0,
    ROLE_MASTER = 1'b1
  } role_e;

  // true when low/per lies inside [lo_pct, hi_pct] percent
  function automatic logic in_band(input int unsigned low, input int unsigned per,
                                   input int unsigned lo_pct, input int unsigned hi_pct);
    return ((low * 100) >= (per * lo_pct)) && ((low * 100) <= (per * hi_pct));
  endfunction

endpackage

// File: rtl/sph_master_gen.sv
module sph_master_gen #(
  parameter int NOM_PERIOD = 250,
  parameter int CNT_W      = 9,
  parameter int SHORT_PCT  = 25,
  parameter int LONG_PCT   = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tx_bit_i,
  output logic pull_o
);

  localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(NOM_PERIOD - 1);
  localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(NOM_PERIOD * SHORT_PCT / 100);
  localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(NOM_PERIOD * LONG_PCT / 100);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] wid_q, wid_d;
  logic [CNT_W-1:0] cur_w;

  always_comb begin
    run_d = en_i;
    cnt_d = cnt_q;
    wid_d = wid_q;
    cur_w = (cnt_q == '0) ? (tx_bit_i ? SHORT_C : LONG_C) : wid_q;
    if (!run_q) begin
      cnt_d = '0;
    end else begin
      wid_d = cur_w;
      cnt_d = (cnt_q == LAST_C) ? '0 : cnt_q + CNT_W'(1);
    end
  end

  assign pull_o = en_i & run_q & (cnt_q < cur_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      wid_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      wid_q <= wid_d;
    end
  end

endmodule

// File: rtl/sph_line_rx.sv
module sph_line_rx
  import sph_pkg::*;
#(
  parameter int NOM_PERIOD = 250,
  parameter int CNT_W      = 9,
  parameter int PER_MIN    = 238,
  parameter int PER_MAX    = 263,
  parameter int SHORT_LO   = 22,
  parameter int SHORT_HI   = 28,
  parameter int LONG_LO    = 72,
  parameter int LONG_HI    = 78
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  output logic             fall_o,
  output logic [CNT_W-1:0] period_o,
  output logic             rx_bit_o,
  output logic             rx_valid_o,
  output logic             err_o,
  output logic             lost_o
);

  localparam logic [CNT_W-1:0] LOSS_C = CNT_W'(2 * NOM_PERIOD);
  localparam logic [CNT_W-1:0] MIN_C  = CNT_W'(PER_MIN);
  localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(PER_MAX);
  localparam logic [CNT_W-1:0] NOM_C  = CNT_W'(NOM_PERIOD);

  logic             s1_q, s2_q, prev_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic             armed_q, armed_d;
  logic             lost_q, lost_d;
  logic             bit_q, bit_d;
  logic             err_q, err_d;
  logic             rise, measure, range_ok, band_ok, cls_bit, rx_ok;

  always_comb begin
    fall_o   = prev_q & ~s2_q;
    rise     = ~prev_q & s2_q;
    range_ok = (cnt_q >= MIN_C) && (cnt_q <= MAX_C);
    measure  = fall_o & armed_q & ~lost_q;
    band_ok  = in_band(32'(cnt_q), 32'(per_q), SHORT_LO, SHORT_HI) |
               in_band(32'(cnt_q), 32'(per_q), LONG_LO, LONG_HI);
    cls_bit  = {cnt_q, 1'b0} < {1'b0, per_q};
    rx_ok    = rise & armed_q & ~lost_q;

    cnt_d = cnt_q;
    if (fall_o)               cnt_d = CNT_W'(1);
    else if (cnt_q != LOSS_C) cnt_d = cnt_q + CNT_W'(1);

    armed_d = armed_q | fall_o;
    lost_d  = fall_o ? 1'b0 : (lost_q | (cnt_q == LOSS_C));
    per_d   = (measure && range_ok) ? cnt_q : per_q;
    bit_d   = rx_ok ? cls_bit : bit_q;

    err_d = err_q;
    if (fall_o)     err_d = measure & ~range_ok;
    else if (rx_ok) err_d = err_q | ~band_ok;
  end

  assign period_o   = per_q;
  assign rx_bit_o   = rx_ok ? cls_bit : bit_q;
  assign rx_valid_o = rx_ok;
  assign err_o      = err_q;
  assign lost_o     = lost_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      prev_q  <= 1'b1;
      cnt_q   <= '0;
      per_q   <= NOM_C;
      armed_q <= 1'b0;
      lost_q  <= 1'b0;
      bit_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      s1_q    <= line_i;
      s2_q    <= s1_q;
      prev_q  <= s2_q;
      cnt_q   <= cnt_d;
      per_q   <= per_d;
      armed_q <= armed_d;
      lost_q  <= lost_d;
      bit_q   <= bit_d;
      err_q   <= err_d;
    end
  end

  // R8
  per_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q >= MIN_C) && (per_q <= MAX_C));

  // R9
  lost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_q && !fall_o) |=> $stable(per_q));

  // R9
  lost_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost_q |-> (cnt_q == LOSS_C));

endmodule

// File: rtl/sph_phase_gen.sv
module sph_phase_gen #(
  parameter int CNT_W  = 9,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              cyc_start_o
);

  localparam int PW = CNT_W + CODE_W;

  logic [PW-1:0]    prod;
  logic [CNT_W-1:0] off;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] tgt_q, tgt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hit;

  always_comb begin
    prod   = PW'(period_i) * PW'(code_i);
    off    = prod[PW-1:CODE_W];
    hit    = pend_q && (cnt_q == tgt_q);
    pend_d = pend_q;
    tgt_d  = tgt_q;
    cnt_d  = cnt_q;
    if (fall_i) begin
      cnt_d  = CNT_W'(1);
      tgt_d  = off;
      pend_d = (off != '0);
    end else if (pend_q) begin
      cnt_d  = cnt_q + CNT_W'(1);
      pend_d = !hit;
    end
    cyc_start_o = fall_i ? (off == '0) : hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      tgt_q  <= '0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      tgt_q  <= tgt_d;
      cnt_q  <= cnt_d;
    end
  end

  // R3
  tgt_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !fall_i) |-> (cnt_q <= tgt_q));

endmodule

// File: rtl/sync_phase_ctrl.sv
module sync_phase_ctrl
  import sph_pkg::*;
#(
  parameter int NOM_PERIOD = 250,
  parameter int CODE_W     = 5,
  parameter int F_NOM      = 500,
  parameter int F_MIN      = 475,
  parameter int F_MAX      = 525,
  parameter int SHORT_PCT  = 25,
  parameter int LONG_PCT   = 75,
  parameter int SHORT_LO   = 22,
  parameter int SHORT_HI   = 28,
  parameter int LONG_LO    = 72,
  parameter int LONG_HI    = 78
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ilv_sel,
  input  logic [CODE_W-1:0] ilv_code,
  input  logic              tx_bit,
  input  logic              sync_in,
  output logic              sync_pull,
  output logic              is_master,
  output logic              cyc_start,
  output logic              rx_bit,
  output logic              rx_valid,
  output logic              sync_err,
  output logic              sync_lost
);

  localparam int CNT_W   = $clog2(2 * NOM_PERIOD + 1);
  localparam int PER_MIN = NOM_PERIOD * F_NOM / F_MAX;
  localparam int PER_MAX = NOM_PERIOD * F_NOM / F_MIN;

  role_e             role;
  logic [CODE_W-1:0] code_eff;
  logic              fall;
  logic [CNT_W-1:0]  period;

  assign role      = (!ilv_sel && (ilv_code == '0)) ? ROLE_MASTER : ROLE_SLAVE;
  assign is_master = (role == ROLE_MASTER);
  assign code_eff  = ilv_sel ? ilv_code : '0;

  sph_master_gen #(
    .NOM_PERIOD(NOM_PERIOD), .CNT_W(CNT_W),
    .SHORT_PCT(SHORT_PCT), .LONG_PCT(LONG_PCT)
  ) u_mst (
    .clk(clk), .rst_n(rst_n), .en_i(is_master), .tx_bit_i(tx_bit), .pull_o(sync_pull)
  );

  sph_line_rx #(
    .NOM_PERIOD(NOM_PERIOD), .CNT_W(CNT_W), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX),
    .SHORT_LO(SHORT_LO), .SHORT_HI(SHORT_HI), .LONG_LO(LONG_LO), .LONG_HI(LONG_HI)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .line_i(sync_in), .fall_o(fall), .period_o(period),
    .rx_bit_o(rx_bit), .rx_valid_o(rx_valid), .err_o(sync_err), .lost_o(sync_lost)
  );

  sph_phase_gen #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_ph (
    .clk(clk), .rst_n(rst_n), .fall_i(fall), .period_i(period), .code_i(code_eff),
    .cyc_start_o(cyc_start)
  );

  // R1
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> !sync_pull);

  // R9
  strobe_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !fall) |-> !sync_lost);

endmodule

// File: tb/tb_sync_phase_ctrl.sv
`timescale 1ns/1ps
module tb_sync_phase_ctrl;

  localparam int NOM = 250;
  localparam int NV  = 9;

  typedef struct packed {
    logic       sel;
    logic [4:0] code;
    logic       dbit;
    logic [9:0] per;
  } vec_t;

  // sel, code, data bit, line period (master vectors use NOM)
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'd0,  1'b1, 10'd250},
    '{1'b0, 5'd0,  1'b0, 10'd250},
    '{1'b1, 5'd16, 1'b1, 10'd250},
    '{1'b1, 5'd24, 1'b0, 10'd250},
    '{1'b1, 5'd8,  1'b1, 10'd240},
    '{1'b1, 5'd31, 1'b0, 10'd260},
    '{1'b1, 5'd1,  1'b1, 10'd250},
    '{1'b0, 5'd5,  1'b1, 10'd250},
    '{1'b1, 5'd0,  1'b0, 10'd250}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic ilv_sel, tx_bit, ext_pull;
  logic [4:0] ilv_code;
  logic line, sync_pull, is_master, cyc_start, rx_bit, rx_valid, sync_err, sync_lost;

  assign line = ~(sync_pull | ext_pull);

  always #4 clk = ~clk;

  sync_phase_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ilv_sel(ilv_sel), .ilv_code(ilv_code), .tx_bit(tx_bit),
    .sync_in(line), .sync_pull(sync_pull), .is_master(is_master), .cyc_start(cyc_start),
    .rx_bit(rx_bit), .rx_valid(rx_valid), .sync_err(sync_err), .sync_lost(sync_lost)
  );

  int nchk = 0, nfail = 0;
  int t = 0, last_fall = -1000, prev_fall = -1000, last_rise = -1000, last_strobe = -1000;
  int nrx = 0;
  logic line_q = 1'b1, last_rx = 1'b0, err_seen = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0d)", req, act, exp, t);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  task automatic step(input logic ext);
    @(negedge clk);
    t++;
    ext_pull = ext;
    #1;
    if (line_q && !line) begin prev_fall = last_fall; last_fall = t; end
    if (!line_q && line) last_rise = t;
    line_q = line;
    if (cyc_start) last_strobe = t;
    if (sync_err) err_seen = 1'b1;
    if (rx_valid) begin last_rx = rx_bit; nrx++; end
  endtask

  task automatic pulses(input int per, input int width, input int n);
    for (int p = 0; p < n; p++)
      for (int c = 0; c < per; c++) step(c < width);
  endtask

  function automatic bit strobe_ok(input int off, input int per);
    return ((t - last_strobe) < per) &&
           (((last_strobe - 2 - off) == last_fall) || ((last_strobe - 2 - off) == prev_fall));
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    rst_n = 1'b0; ilv_sel = 1'b1; ilv_code = 5'd3; tx_bit = 1'b1; ext_pull = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!cyc_start && !rx_valid && !sync_err && !sync_lost && !sync_pull, "R10 in reset",
        {cyc_start, rx_valid, sync_err, sync_lost, sync_pull}, 0);
    rst_n = 1'b1;
    repeat (5) step(1'b0);
    chk(!cyc_start && !rx_valid && !sync_err && !sync_lost && !sync_pull, "R10 after release",
        {cyc_start, rx_valid, sync_err, sync_lost, sync_pull}, 0);

    // table-driven main function
    for (int v = 0; v < NV; v++) begin
      automatic vec_t vc  = VECS[v];
      automatic bit   mst = !vc.sel && (vc.code == 5'd0);
      automatic int   per = mst ? NOM : int'(vc.per);
      automatic int   k   = vc.sel ? int'(vc.code) : 0;
      automatic int   off = (per * k) / 32;
      automatic int   w   = vc.dbit ? per * 25 / 100 : per * 75 / 100;
      ilv_sel = vc.sel; ilv_code = vc.code; tx_bit = vc.dbit;
      for (int p = 0; p < 8; p++) begin
        automatic int nrx0 = nrx;
        err_seen = 1'b0;
        if (mst) begin for (int c = 0; c < per; c++) step(1'b0); end
        else pulses(per, w, 1);
        if (p >= 4) begin
          chk(strobe_ok(off, per), "R3 R4 R5 strobe placement", last_strobe - last_fall, 2 + off);
          chk(nrx > nrx0 && last_rx == vc.dbit, "R6 data bit", last_rx, vc.dbit);
          chk(!err_seen, "R7 no error on clean pulses", err_seen, 0);
          if (mst) begin
            chk((last_fall - prev_fall) == NOM, "R2 master period", last_fall - prev_fall, NOM);
            if (last_rise > last_fall)
              chk((last_rise - last_fall) == w, "R2 master pulse width", last_rise - last_fall, w);
          end
        end
      end
      chk(is_master == mst, "R1 role decode", is_master, mst);
      if (!mst) chk(!sync_pull, "R1 slave silent", sync_pull, 0);
    end

    // R7: a 50 % pulse belongs to neither band
    ilv_sel = 1'b1; ilv_code = 5'd16;
    pulses(250, 62, 4);
    err_seen = 1'b0;
    pulses(250, 125, 1);
    chk(err_seen, "R7 mid-width pulse flagged", err_seen, 1);
    pulses(250, 62, 1);
    chk(!sync_err, "R7 flag cleared by clean period", sync_err, 0);

    // R8: out-of-range interval is flagged and not stored
    pulses(250, 62, 3);
    pulses(300, 62, 3);
    chk(sync_err, "R8 long interval flagged", sync_err, 1);
    chk(strobe_ok(125, 300), "R8 period kept at 250", last_strobe - last_fall, 2 + 125);

    // R9: loss of sync, held period
    pulses(240, 60, 5);
    chk(strobe_ok(120, 240), "R5 period 240 learned", last_strobe - last_fall, 122);
    while (t < last_fall + 2 * NOM - 10) step(1'b0);
    chk(!sync_lost, "R9 not lost before limit", sync_lost, 0);
    while (t < last_fall + 2 * NOM + 10) step(1'b0);
    chk(sync_lost, "R9 lost after limit", sync_lost, 1);
    pulses(240, 60, 1);
    chk(!sync_lost, "R9 lost cleared by edge", sync_lost, 0);
    chk(strobe_ok(120, 240), "R9 strobe uses held period", last_strobe - last_fall, 122);

    summary();
  end

endmodule